// File: doc/BRIEF.md
# Grouped Interrupt Mask Controller

This block gathers completion events from a set of transmit channels and a set of receive channels, plus a small group of DMA-level error events, and turns them into one interrupt line for a processor. Each of the three groups keeps a raw status vector, in which every event pulse latches a sticky bit, and a mask vector that selects which of those bits may raise the interrupt. A channel's bit is one shifted left by the channel's index within its group. In the error group, bit 1 carries the host-error event.

Software talks to the block over a simple 32-bit register bus. It can read the raw and the masked status of each group. It changes a mask only by writing ones to a set register or to a clear register. A sticky raw bit is removed by the channel's own acknowledge input. A vector register shows which groups have masked work pending. An end-of-interrupt register drops the interrupt line for one cycle, so that an edge-sensitive receiver sees a fresh edge when work is still left.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset every raw and mask bit is zero, irq_o is low, and every readable register returns zero.
- R2: A one-cycle pulse on bit i of tx_evt, rx_evt or err_evt sets bit i of that group's raw status from the next clock, readable at 0x80 (transmit), 0xA0 (receive) or 0xB0 (error); err_evt bit 1 is the host error and appears as bit 1 at 0xB0.
- R3: A raw bit stays set until its ack input bit is high for a clock; an event and an ack on the same bit in the same cycle leave the bit set.
- R4: Writing a word to a mask-set register (0x88, 0xA8, 0xB8) turns on the mask bits that are one in the word from the following clock; zero bits change nothing; reading either the set or the clear register of a group returns its mask.
- R5: Writing a word to a mask-clear register (0x8C, 0xAC, 0xBC) turns off the mask bits that are one in it from the following clock; writing all ones turns off the whole group.
- R6: The masked status read at 0x84, 0xA4 or 0xB4 equals that group's raw status ANDed with its mask.
- R7: irq_o is high exactly when any masked status bit in any group is set, except in the cycle named in R8.
- R8: A write to 0x94 whose bits [1:0] are 0, 1 or 2 forces irq_o low for the one cycle after the write; after that irq_o follows R7 again; a write with bits [1:0] equal to 3 has no effect on irq_o.
- R9: Reading 0x90 returns bit 0 set when the transmit group has a masked bit pending, bit 1 for the receive group and bit 2 for the error group, other bits zero.
- R10: Writes to the raw, masked status and vector registers or to unmapped offsets change no state; reads of 0x94 and unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |
| tx_evt | input | N_TX | Transmit completion pulses, one bit per channel |
| tx_ack | input | N_TX | Transmit acknowledge, clears raw bits |
| rx_evt | input | N_RX | Receive completion pulses |
| rx_ack | input | N_RX | Receive acknowledge |
| err_evt | input | N_ERR | DMA-level error pulses, bit 1 host error |
| err_ack | input | N_ERR | Error acknowledge |
| irq_o | output | 1 | Combined interrupt |

## Verification
Read data is combinational, so a read is sampled in its own cycle just before the next clock edge. Every state change caused by an event, an acknowledge or a register write is due one clock after the input is presented; the bench drives inputs on the falling edge, lets exactly one rising edge pass and samples on the next falling edge, and for the mask write it also samples irq_o before that edge to show the old mask still holds. The end-of-interrupt gap is checked on the first falling edge after the write (low) and again one cycle later (high again while work remains).

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;

  localparam int unsigned BUS_AW = 8;
  localparam int unsigned BUS_DW = 32;
  localparam int unsigned NUM_GRP = 3;

  // group order fixes the vector bit and the end-of-interrupt code
  typedef enum logic [1:0] {
    GRP_TX  = 2'd0,
    GRP_RX  = 2'd1,
    GRP_ERR = 2'd2,
    GRP_NONE = 2'd3
  } grp_e;

  localparam logic [BUS_AW-1:0] OFS_RAW    = 8'h0;
  localparam logic [BUS_AW-1:0] OFS_MASKED = 8'h4;
  localparam logic [BUS_AW-1:0] OFS_SET    = 8'h8;
  localparam logic [BUS_AW-1:0] OFS_CLR    = 8'hC;

  localparam logic [BUS_AW-1:0] ADDR_VEC = 8'h90;
  localparam logic [BUS_AW-1:0] ADDR_EOI = 8'h94;

  function automatic logic [BUS_AW-1:0] grp_base(input int unsigned g);
    case (g)
      0:       grp_base = 8'h80;
      1:       grp_base = 8'hA0;
      default: grp_base = 8'hB0;
    endcase
  endfunction

endpackage

// File: rtl/irq_grp_core.sv
module irq_grp_core #(
  parameter int unsigned W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [W-1:0]                      evt,
  input  logic [W-1:0]                      ack,
  input  logic                              set_we,
  input  logic                              clr_we,
  input  logic [W-1:0]                      wdata,
  output logic [W-1:0]                      raw_q,
  output logic [W-1:0]                      mask_q,
  output logic [irq_mask_pkg::BUS_DW-1:0]   raw_ext,
  output logic [irq_mask_pkg::BUS_DW-1:0]   mask_ext,
  output logic                              pend
);

  logic [W-1:0] raw_d;
  logic [W-1:0] mask_d;
  logic         raw_en;
  logic         mask_en;

  // event wins over ack on the same bit
  always_comb begin
    raw_en = (|evt) | (|ack);
    raw_d  = (raw_q & ~ack) | evt;
  end

  always_comb begin
    mask_en = set_we | clr_we;
    mask_d  = mask_q;
    if (set_we) begin
      mask_d = mask_q | wdata;
    end else if (clr_we) begin
      mask_d = mask_q & ~wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
    end else if (raw_en) begin
      raw_q <= raw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  always_comb begin
    raw_ext  = '0;
    mask_ext = '0;
    raw_ext[W-1:0]  = raw_q;
    mask_ext[W-1:0] = mask_q;
    pend = |(raw_q & mask_q);
  end

endmodule

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_mask_pkg::*;
(
  input  logic                             bus_en,
  input  logic                             bus_we,
  input  logic [BUS_AW-1:0]                bus_addr,
  input  logic [1:0]                       eoi_code,
  input  logic [NUM_GRP-1:0][BUS_DW-1:0]   raw_w,
  input  logic [NUM_GRP-1:0][BUS_DW-1:0]   mask_w,
  input  logic [NUM_GRP-1:0]               pend,
  output logic [NUM_GRP-1:0]               set_we,
  output logic [NUM_GRP-1:0]               clr_we,
  output logic                             eoi_req,
  output logic [BUS_DW-1:0]                rdata
);

  logic wr_acc;
  logic rd_acc;

  assign wr_acc = bus_en & bus_we;
  assign rd_acc = bus_en & ~bus_we;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_wdec
    assign set_we[g] = wr_acc & (bus_addr == (grp_base(g) | OFS_SET));
    assign clr_we[g] = wr_acc & (bus_addr == (grp_base(g) | OFS_CLR));
  end

  assign eoi_req = wr_acc & (bus_addr == ADDR_EOI) & (grp_e'(eoi_code) != GRP_NONE);

  always_comb begin
    rdata = '0;
    if (rd_acc) begin
      for (int g = 0; g < NUM_GRP; g++) begin
        if (bus_addr == (grp_base(g) | OFS_RAW)) begin
          rdata = raw_w[g];
        end
        if (bus_addr == (grp_base(g) | OFS_MASKED)) begin
          rdata = raw_w[g] & mask_w[g];
        end
        if ((bus_addr == (grp_base(g) | OFS_SET)) ||
            (bus_addr == (grp_base(g) | OFS_CLR))) begin
          rdata = mask_w[g];
        end
      end
      if (bus_addr == ADDR_VEC) begin
        rdata[NUM_GRP-1:0] = pend;
      end
    end
  end

endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irq_mask_pkg::*;
#(
  parameter int unsigned N_TX  = 8,
  parameter int unsigned N_RX  = 8,
  parameter int unsigned N_ERR = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N_TX-1:0]   tx_evt,
  input  logic [N_TX-1:0]   tx_ack,
  input  logic [N_RX-1:0]   rx_evt,
  input  logic [N_RX-1:0]   rx_ack,
  input  logic [N_ERR-1:0]  err_evt,
  input  logic [N_ERR-1:0]  err_ack,
  output logic              irq_o
);

  logic [N_TX-1:0]  tx_raw_q,  tx_mask_q;
  logic [N_RX-1:0]  rx_raw_q,  rx_mask_q;
  logic [N_ERR-1:0] err_raw_q, err_mask_q;

  logic [NUM_GRP-1:0][BUS_DW-1:0] raw_w;
  logic [NUM_GRP-1:0][BUS_DW-1:0] mask_w;
  logic [NUM_GRP-1:0]             pend;
  logic [NUM_GRP-1:0]             set_we;
  logic [NUM_GRP-1:0]             clr_we;
  logic                           eoi_req;
  logic                           gap_d, gap_q;

  irq_grp_core #(.W(N_TX)) u_tx (
    .clk(clk), .rst_n(rst_n), .evt(tx_evt), .ack(tx_ack),
    .set_we(set_we[GRP_TX]), .clr_we(clr_we[GRP_TX]),
    .wdata(bus_wdata[N_TX-1:0]), .raw_q(tx_raw_q), .mask_q(tx_mask_q),
    .raw_ext(raw_w[GRP_TX]), .mask_ext(mask_w[GRP_TX]), .pend(pend[GRP_TX])
  );

  irq_grp_core #(.W(N_RX)) u_rx (
    .clk(clk), .rst_n(rst_n), .evt(rx_evt), .ack(rx_ack),
    .set_we(set_we[GRP_RX]), .clr_we(clr_we[GRP_RX]),
    .wdata(bus_wdata[N_RX-1:0]), .raw_q(rx_raw_q), .mask_q(rx_mask_q),
    .raw_ext(raw_w[GRP_RX]), .mask_ext(mask_w[GRP_RX]), .pend(pend[GRP_RX])
  );

  irq_grp_core #(.W(N_ERR)) u_err (
    .clk(clk), .rst_n(rst_n), .evt(err_evt), .ack(err_ack),
    .set_we(set_we[GRP_ERR]), .clr_we(clr_we[GRP_ERR]),
    .wdata(bus_wdata[N_ERR-1:0]), .raw_q(err_raw_q), .mask_q(err_mask_q),
    .raw_ext(raw_w[GRP_ERR]), .mask_ext(mask_w[GRP_ERR]), .pend(pend[GRP_ERR])
  );

  irq_bus_decode u_dec (
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .eoi_code(bus_wdata[1:0]), .raw_w(raw_w), .mask_w(mask_w), .pend(pend),
    .set_we(set_we), .clr_we(clr_we), .eoi_req(eoi_req), .rdata(bus_rdata)
  );

  // one-cycle gap after an end-of-interrupt write
  always_comb begin
    gap_d = eoi_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= 1'b0;
    end else begin
      gap_q <= gap_d;
    end
  end

  assign irq_o = (|pend) & ~gap_q;

endmodule

// File: rtl/irq_mask_ctrl_chk.sv
module irq_mask_ctrl_chk
  import irq_mask_pkg::*;
#(
  parameter int unsigned N_TX  = 8,
  parameter int unsigned N_RX  = 8,
  parameter int unsigned N_ERR = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [7:0]        bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [N_TX-1:0]   tx_evt,
  input logic [N_TX-1:0]   tx_ack,
  input logic [N_TX-1:0]   tx_raw_q,
  input logic [N_TX-1:0]   tx_mask_q,
  input logic [N_RX-1:0]   rx_raw_q,
  input logic [N_RX-1:0]   rx_mask_q,
  input logic [N_ERR-1:0]  err_raw_q,
  input logic [N_ERR-1:0]  err_mask_q,
  input logic              irq_o
);

  logic wr_set_tx, wr_clr_tx, wr_eoi;
  assign wr_set_tx = bus_en && bus_we && (bus_addr == 8'h88);
  assign wr_clr_tx = bus_en && bus_we && (bus_addr == 8'h8C);
  assign wr_eoi    = bus_en && bus_we && (bus_addr == 8'h94) && (bus_wdata[1:0] != 2'd3);

  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_evt != '0) |=> ((tx_raw_q & $past(tx_evt)) == $past(tx_evt)));

  assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_ack != '0) && (tx_evt == '0)) |=> ((tx_raw_q & $past(tx_ack)) == '0));

  assert_set_applies_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set_tx |=> ((tx_mask_q & $past(bus_wdata[N_TX-1:0])) == $past(bus_wdata[N_TX-1:0])));

  assert_mask_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set_tx || wr_clr_tx) |=> $stable(tx_mask_q));

  assert_clr_applies_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr_tx |=> ((tx_mask_q & $past(bus_wdata[N_TX-1:0])) == '0));

  assert_irq_has_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (((tx_raw_q & tx_mask_q) != '0) || ((rx_raw_q & rx_mask_q) != '0) ||
               ((err_raw_q & err_mask_q) != '0)));

  assert_eoi_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_eoi |=> !irq_o);

endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(.N_TX(N_TX), .N_RX(N_RX), .N_ERR(N_ERR)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .tx_evt(tx_evt), .tx_ack(tx_ack),
  .tx_raw_q(tx_raw_q), .tx_mask_q(tx_mask_q),
  .rx_raw_q(rx_raw_q), .rx_mask_q(rx_mask_q),
  .err_raw_q(err_raw_q), .err_mask_q(err_mask_q),
  .irq_o(irq_o)
);

// File: tb/irq_mask_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_mask_ctrl_tb_top;

  localparam int unsigned N_TX  = 8;
  localparam int unsigned N_RX  = 8;
  localparam int unsigned N_ERR = 4;

  logic              clk;
  logic              rst_n;
  logic              bus_en;
  logic              bus_we;
  logic [7:0]        bus_addr;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;
  logic [N_TX-1:0]   tx_evt, tx_ack;
  logic [N_RX-1:0]   rx_evt, rx_ack;
  logic [N_ERR-1:0]  err_evt, err_ack;
  logic              irq_o;

  int checks;
  int failures;
  bit done;

  irq_mask_ctrl #(.N_TX(N_TX), .N_RX(N_RX), .N_ERR(N_ERR)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_evt(tx_evt), .tx_ack(tx_ack), .rx_evt(rx_evt), .rx_ack(rx_ack),
    .err_evt(err_evt), .err_ack(err_ack), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0; bus_addr = '0;
  endtask

  task automatic pulse(input logic [N_TX-1:0] te, input logic [N_TX-1:0] ta,
                       input logic [N_RX-1:0] re, input logic [N_ERR-1:0] ee);
    @(negedge clk);
    tx_evt = te; tx_ack = ta; rx_evt = re; err_evt = ee;
    @(negedge clk);
    tx_evt = '0; tx_ack = '0; rx_evt = '0; err_evt = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq_o", {31'd0, irq_o}, 32'd0);
    bus_read(8'h80, d); chk("R1 tx raw", d, 32'd0);
    bus_read(8'h88, d); chk("R1 tx mask", d, 32'd0);
    bus_read(8'hA0, d); chk("R1 rx raw", d, 32'd0);
    bus_read(8'hB8, d); chk("R1 err mask", d, 32'd0);
    bus_read(8'h90, d); chk("R1 vector", d, 32'd0);
  endtask

  task automatic t_tx_event();
    logic [31:0] d;
    pulse(8'h05, 8'h00, 8'h00, 4'h0);
    bus_read(8'h80, d); chk("R2 tx raw after pulse", d, 32'h05);
    bus_read(8'h84, d); chk("R6 tx masked with empty mask", d, 32'h0);
    chk("R7 irq low with empty mask", {31'd0, irq_o}, 32'd0);
    repeat (3) @(negedge clk);
    bus_read(8'h80, d); chk("R3 tx raw sticky", d, 32'h05);
  endtask

  task automatic t_mask_set();
    logic [31:0] d;
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 8'h88; bus_wdata = 32'h04;
    #1 chk("R4 old mask before edge", {31'd0, irq_o}, 32'd0);
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    chk("R7 irq high after mask", {31'd0, irq_o}, 32'd1);
    bus_read(8'h88, d); chk("R4 mask readback", d, 32'h04);
    bus_read(8'h8C, d); chk("R4 mask readback at clear", d, 32'h04);
    bus_read(8'h84, d); chk("R6 tx masked", d, 32'h04);
    bus_write(8'h88, 32'h0);
    bus_read(8'h88, d); chk("R4 zero write no effect", d, 32'h04);
    bus_read(8'h90, d); chk("R9 vector tx", d, 32'h1);
  endtask

  task automatic t_ack();
    logic [31:0] d;
    pulse(8'h00, 8'h04, 8'h00, 4'h0);
    bus_read(8'h80, d); chk("R3 ack clears bit2", d, 32'h01);
    chk("R7 irq low after ack", {31'd0, irq_o}, 32'd0);
    pulse(8'h01, 8'h01, 8'h00, 4'h0);
    bus_read(8'h80, d); chk("R3 event beats ack", d, 32'h01);
  endtask

  task automatic t_rx_err();
    logic [31:0] d;
    pulse(8'h00, 8'h00, 8'h80, 4'b0010);
    bus_read(8'hA0, d); chk("R2 rx raw", d, 32'h80);
    bus_read(8'hB0, d); chk("R2 host error bit1", d, 32'h02);
    bus_write(8'hB8, 32'h02);
    bus_read(8'h90, d); chk("R9 vector err", d, 32'h4);
    bus_read(8'hB4, d); chk("R6 err masked", d, 32'h02);
    chk("R7 irq from err group", {31'd0, irq_o}, 32'd1);
  endtask

  task automatic t_eoi();
    bus_write(8'h94, 32'h2);
    chk("R8 irq gap after eoi", {31'd0, irq_o}, 32'd0);
    @(negedge clk);
    chk("R8 irq back after gap", {31'd0, irq_o}, 32'd1);
    bus_write(8'h94, 32'h3);
    chk("R8 code 3 ignored", {31'd0, irq_o}, 32'd1);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    bus_write(8'hBC, 32'hFFFF_FFFF);
    bus_read(8'hB8, d); chk("R5 all-ones clear", d, 32'h0);
    bus_read(8'hB4, d); chk("R5 err masked cleared", d, 32'h0);
    bus_read(8'hB0, d); chk("R5 raw kept", d, 32'h02);
    chk("R7 irq low with nothing masked", {31'd0, irq_o}, 32'd0);
    bus_write(8'h8C, 32'h04);
    bus_read(8'h88, d); chk("R5 tx mask cleared", d, 32'h0);
  endtask

  task automatic t_readonly();
    logic [31:0] d;
    bus_write(8'h80, 32'hFF);
    bus_write(8'hB0, 32'h0);
    bus_write(8'h90, 32'hF);
    bus_write(8'h60, 32'hFFFF_FFFF);
    bus_read(8'h80, d); chk("R10 tx raw unchanged", d, 32'h01);
    bus_read(8'hB0, d); chk("R10 err raw unchanged", d, 32'h02);
    bus_read(8'hA8, d); chk("R10 rx mask unchanged", d, 32'h0);
    bus_read(8'h94, d); chk("R10 eoi reads zero", d, 32'h0);
    bus_read(8'h60, d); chk("R10 unmapped reads zero", d, 32'h0);
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0;
    bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    tx_evt = '0; tx_ack = '0; rx_evt = '0; rx_ack = '0; err_evt = '0; err_ack = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_event();
    t_mask_set();
    t_ack();
    t_rx_err();
    t_eoi();
    t_clear();
    t_readonly();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule